// File: doc/BRIEF.md
# UART Bit-Rate and Line-Break Timer

This block derives the two timing strobes a serial transmitter and receiver need from the system clock. The first is a sample strobe at thirteen times the bit rate. The second is a bit strobe once per bit. The rate is set by two cascaded counters, a coarse prescaler and a fine divisor. Software loads both at once as one packed rate word. Each field holds its division ratio minus one.

A rate change does not cut a bit short. A written word is parked until the current bit ends. A busy flag stays high during that wait, and further rate writes are dropped until it clears. The same block also times line breaks. Software stores a break length, counted in whole bit periods, and pulses a break request. The serial output is then forced low for that many bit strobes, and a one-cycle completion strobe follows.

Top module: `uart_rate_brk`

## Requirements
- R1: In the rate word, bits [9:0] hold the divisor minus one (D) and bits [19:16] hold the prescaler minus one (P). Bits [15:10] are ignored.
- R2: While a rate (P, D) is in force, `sample_tick` is high for one cycle every (P+1)·(D+1) clock cycles.
- R3: An internal oversampling count runs from 0 to 12 on sample ticks and then wraps. `bit_tick` rises on the sample tick where it wraps, so every bit period holds exactly 13 sample ticks and lasts 13·(P+1)·(D+1) cycles.
- R4: An accepted rate write raises `busy` in the next cycle. The bit period in progress finishes at the old rate. The new rate applies from the next bit boundary, and `busy` falls at that same edge.
- R5: A rate write made while `busy` is high is ignored.
- R6: A one-cycle pulse on `brk_start` while no break is running sets `brk_active` in the next cycle. A pulse during a running break has no effect.
- R7: A break lasts for N bit ticks, where N is the stored break length when the break started, and a stored length of 0 acts as 1. On the Nth bit tick the break ends and `brk_done` is high for exactly one cycle.
- R8: `tx_out` is low while `brk_active` is high and equals `tx_in` otherwise.
- R9: After reset, P and D are 0 (bit period of 13 cycles), `busy` is low and no break is running.
- R10: A break-length write during a running break does not change the length of that break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_we | input | 1 | Rate word write strobe |
| rate_wdata | input | 20 | Packed rate word (divisor and prescaler fields) |
| brk_len_we | input | 1 | Break-length write strobe |
| brk_len_wdata | input | 16 | Break length in bit periods |
| brk_start | input | 1 | Break request pulse |
| tx_in | input | 1 | Serial data from the transmit shifter |
| busy | output | 1 | Rate change pending |
| sample_tick | output | 1 | Oversampling strobe (13 per bit) |
| bit_tick | output | 1 | Bit-boundary strobe |
| brk_active | output | 1 | Break in progress |
| brk_done | output | 1 | One-cycle strobe at break end |
| tx_out | output | 1 | Serial line, forced low during a break |

## Verification
A rate change and the end of a break both happen on a bit tick, so they can land on the same edge. The bench starts a break three bits long. Right after the second bit tick inside that break, it writes a new rate. The pending rate is then applied on the third tick, the same edge that ends the break. The bench checks that `busy` falls in the same cycle that `brk_done` pulses, that the break still counted exactly three ticks, and that the following bit periods, scored against a queue of expected lengths, use the new rate.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;
   // Field positions inside the packed rate word (software-visible layout)
   localparam int unsigned URB_DIV_LSB = 0;
   localparam int unsigned URB_PRE_LSB = 16;
   // Oversampling ratio per bit
   localparam int unsigned URB_OVS_DEF = 13;

   typedef enum logic {
      RATE_IDLE    = 1'b0,
      RATE_PENDING = 1'b1
   } rate_state_e;
endpackage

// File: rtl/urb_stage.sv
// One wrap-around counter stage of the rate chain: advances on en,
// wraps to zero after reaching limit and flags the wrap cycle.
module urb_stage #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] limit,
   output logic         wrap
);
   logic [W-1:0] cnt_q;
   logic         at_end;

   assign at_end = (cnt_q >= limit);
   assign wrap   = en && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en) begin
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/urb_rate_ctrl.sv
// Holds the active prescaler/divisor pair and a parked copy that is
// promoted on the next bit boundary.
module urb_rate_ctrl
   import uart_rate_pkg::*;
#(
   parameter int unsigned WORD_W = 20,
   parameter int unsigned PRE_W  = 4,
   parameter int unsigned DIV_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              bit_tick,
   output logic              busy,
   output logic [PRE_W-1:0]  act_pre,
   output logic [DIV_W-1:0]  act_div
);
   rate_state_e      st_q;
   logic [PRE_W-1:0] pend_pre_q;
   logic [DIV_W-1:0] pend_div_q;
   logic [PRE_W-1:0] wr_pre;
   logic [DIV_W-1:0] wr_div;

   assign wr_pre = wdata[URB_PRE_LSB +: PRE_W];
   assign wr_div = wdata[URB_DIV_LSB +: DIV_W];
   assign busy   = (st_q == RATE_PENDING);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= RATE_IDLE;
         pend_pre_q <= '0;
         pend_div_q <= '0;
         act_pre    <= '0;
         act_div    <= '0;
      end else begin
         case (st_q)
            RATE_IDLE: begin
               if (wr) begin
                  pend_pre_q <= wr_pre;
                  pend_div_q <= wr_div;
                  st_q       <= RATE_PENDING;
               end
            end
            RATE_PENDING: begin
               if (bit_tick) begin
                  act_pre <= pend_pre_q;
                  act_div <= pend_div_q;
                  st_q    <= RATE_IDLE;
               end
            end
            default: st_q <= RATE_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/urb_break_timer.sv
// Counts bit ticks while the line is held in break.
module urb_break_timer #(
   parameter int unsigned BRK_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_we,
   input  logic [BRK_W-1:0] len_wdata,
   input  logic             start,
   input  logic             bit_tick,
   output logic             active,
   output logic             done
);
   logic [BRK_W-1:0] len_q;
   logic [BRK_W-1:0] len_lat_q;
   logic [BRK_W-1:0] cnt_q;
   logic [BRK_W:0]   cnt_next;

   assign cnt_next = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q     <= '0;
         len_lat_q <= '0;
         cnt_q     <= '0;
         active    <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (len_we) begin
            len_q <= len_wdata;
         end
         if (!active) begin
            if (start) begin
               active    <= 1'b1;
               cnt_q     <= '0;
               len_lat_q <= (len_q == '0) ? {{(BRK_W-1){1'b0}}, 1'b1} : len_q;
            end
         end else if (bit_tick) begin
            if (cnt_next >= {1'b0, len_lat_q}) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               cnt_q <= cnt_next[BRK_W-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/uart_rate_brk.sv
module uart_rate_brk
   import uart_rate_pkg::*;
#(
   parameter int unsigned WORD_W = 20,
   parameter int unsigned PRE_W  = 4,
   parameter int unsigned DIV_W  = 10,
   parameter int unsigned OVS    = URB_OVS_DEF,
   parameter int unsigned BRK_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rate_we,
   input  logic [WORD_W-1:0] rate_wdata,
   input  logic              brk_len_we,
   input  logic [BRK_W-1:0]  brk_len_wdata,
   input  logic              brk_start,
   input  logic              tx_in,
   output logic              busy,
   output logic              sample_tick,
   output logic              bit_tick,
   output logic              brk_active,
   output logic              brk_done,
   output logic              tx_out
);
   localparam int unsigned OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [OVS_W-1:0] OVS_LIM = OVS_W'(OVS - 1);

   // elaboration-time parameter checks
   if (PRE_W < 1 || DIV_W < 1) begin : g_bad_width
      $error("uart_rate_brk: PRE_W and DIV_W must be at least 1");
   end
   if (URB_DIV_LSB + DIV_W > URB_PRE_LSB) begin : g_bad_div
      $error("uart_rate_brk: divisor field overlaps prescaler field");
   end
   if (URB_PRE_LSB + PRE_W > WORD_W) begin : g_bad_word
      $error("uart_rate_brk: rate word too narrow for prescaler field");
   end
   if (OVS < 2) begin : g_bad_ovs
      $error("uart_rate_brk: oversampling ratio must be at least 2");
   end
   if (BRK_W < 2) begin : g_bad_brk
      $error("uart_rate_brk: BRK_W must be at least 2");
   end

   logic [PRE_W-1:0] act_pre;
   logic [DIV_W-1:0] act_div;
   logic             pre_tick;

   urb_rate_ctrl #(
      .WORD_W (WORD_W),
      .PRE_W  (PRE_W),
      .DIV_W  (DIV_W)
   ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (rate_we),
      .wdata    (rate_wdata),
      .bit_tick (bit_tick),
      .busy     (busy),
      .act_pre  (act_pre),
      .act_div  (act_div)
   );

   // prescaler -> divisor -> oversampling cascade
   urb_stage #(.W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .limit (act_pre),
      .wrap  (pre_tick)
   );

   urb_stage #(.W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (pre_tick),
      .limit (act_div),
      .wrap  (sample_tick)
   );

   urb_stage #(.W(OVS_W)) u_ovs (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sample_tick),
      .limit (OVS_LIM),
      .wrap  (bit_tick)
   );

   urb_break_timer #(.BRK_W(BRK_W)) u_brk (
      .clk       (clk),
      .rst_n     (rst_n),
      .len_we    (brk_len_we),
      .len_wdata (brk_len_wdata),
      .start     (brk_start),
      .bit_tick  (bit_tick),
      .active    (brk_active),
      .done      (brk_done)
   );

   assign tx_out = brk_active ? 1'b0 : tx_in;
endmodule

// File: rtl/uart_rate_brk_chk.sv
module uart_rate_brk_chk #(
   parameter int unsigned WORD_W = 20,
   parameter int unsigned BRK_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rate_we,
   input logic [WORD_W-1:0] rate_wdata,
   input logic              brk_len_we,
   input logic [BRK_W-1:0]  brk_len_wdata,
   input logic              brk_start,
   input logic              tx_in,
   input logic              busy,
   input logic              sample_tick,
   input logic              bit_tick,
   input logic              brk_active,
   input logic              brk_done,
   input logic              tx_out
);
   AST_BUSY_DROP_AT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(bit_tick)); // R4
   AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_we && !busy) |=> busy); // R4
   AST_BIT_IS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> sample_tick); // R3
   AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> !bit_tick); // R3
   AST_BRK_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_active) |-> $past(brk_start)); // R6
   AST_DONE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      brk_done |-> ($past(bit_tick) && $past(brk_active) && !brk_active)); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      brk_done |=> !brk_done); // R7
   AST_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_active |-> (tx_out == tx_in)); // R8
endmodule

bind uart_rate_brk uart_rate_brk_chk #(.WORD_W(WORD_W), .BRK_W(BRK_W)) u_chk (.*);

// File: tb/uart_rate_brk_tb.sv
`timescale 1ns/1ps
module uart_rate_brk_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rate_we = 1'b0;
   logic [19:0] rate_wdata = '0;
   logic        brk_len_we = 1'b0;
   logic [15:0] brk_len_wdata = '0;
   logic        brk_start = 1'b0;
   logic        tx_in = 1'b1;
   logic        busy, sample_tick, bit_tick, brk_active, brk_done, tx_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   int exp_q[$];
   int exp_sp = 0;
   int cyc = 0;
   int last_b = 0;
   int last_s = 0;
   int n_samp = 0;

   always #5 clk = ~clk;

   uart_rate_brk u_dut (
      .clk(clk), .rst_n(rst_n),
      .rate_we(rate_we), .rate_wdata(rate_wdata),
      .brk_len_we(brk_len_we), .brk_len_wdata(brk_len_wdata),
      .brk_start(brk_start), .tx_in(tx_in),
      .busy(busy), .sample_tick(sample_tick), .bit_tick(bit_tick),
      .brk_active(brk_active), .brk_done(brk_done), .tx_out(tx_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: scores bit periods and sample spacing against the queue
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n && sample_tick) begin
            n_samp++;
            if (exp_q.size() > 0 && exp_sp > 0)
               chk(cyc - last_s == exp_sp, "R2 sample spacing", cyc - last_s, exp_sp);
            last_s = cyc;
         end
         if (rst_n && bit_tick) begin
            if (exp_q.size() > 0) begin
               int e;
               e = exp_q.pop_front();
               chk(cyc - last_b == e, "R3 bit period", cyc - last_b, e);
               chk(n_samp == 13, "R3 samples per bit", n_samp, 13);
            end
            n_samp = 0;
            last_b = cyc;
         end
      end
   end

   task automatic sync_bit();
      do @(negedge clk); while (!bit_tick);
      @(negedge clk);
   endtask

   task automatic expect_bits(input int n, input int pre, input int dv);
      exp_sp = (pre + 1) * (dv + 1);
      for (int i = 0; i < n; i++) exp_q.push_back(13 * exp_sp);
      while (exp_q.size() > 0) @(negedge clk);
   endtask

   task automatic write_rate(input logic [19:0] w);
      rate_wdata = w;
      rate_we = 1'b1;
      @(negedge clk);
      rate_we = 1'b0;
   endtask

   task automatic wait_not_busy();
      while (busy) @(negedge clk);
   endtask

   // full rate-change sequence: old period completes, then new rate
   task automatic change_rate(input logic [19:0] w, input int old_p, input int old_d,
                              input int pre, input int dv);
      sync_bit();
      exp_sp = (old_p + 1) * (old_d + 1);
      exp_q.push_back(13 * exp_sp);
      write_rate(w);
      chk(busy == 1'b1, "R4 busy after write", busy, 1);
      wait_not_busy();
      expect_bits(2, pre, dv);
   endtask

   // break run: mode 1 = extra start + length write mid-break,
   // mode 2 = rate write after tick div_at (same-cycle case)
   task automatic run_break(input int len, input int exp_ticks, input int mode,
                            input int div_at, input logic [19:0] w);
      int ticks, low_err, guard;
      bit div_done;
      ticks = 0; low_err = 0; guard = 0; div_done = 0;
      brk_len_wdata = 16'(len);
      brk_len_we = 1'b1;
      @(negedge clk);
      brk_len_we = 1'b0;
      brk_start = 1'b1;
      @(negedge clk);
      brk_start = 1'b0;
      chk(brk_active == 1'b1, "R6 break starts", brk_active, 1);
      while (!brk_done && guard < 20000) begin
         if (brk_active) begin
            if (tx_out !== 1'b0) low_err++;
            if (bit_tick) ticks++;
         end
         if (mode == 1 && ticks == 1 && !brk_start && !brk_len_we && guard < 40) begin
            brk_start = 1'b1;
            brk_len_we = 1'b1;
            brk_len_wdata = 16'd9;
         end
         if (mode == 2 && ticks == div_at && bit_tick && !div_done) begin
            rate_wdata = w;
            rate_we = 1'b1;
            div_done = 1;
         end
         @(negedge clk);
         brk_start = 1'b0;
         brk_len_we = 1'b0;
         rate_we = 1'b0;
         guard++;
      end
      chk(ticks == exp_ticks, (mode == 1) ? "R10 R6 break length kept" :
                              (len == 0) ? "R7 zero length as one" : "R7 break length",
          ticks, exp_ticks);
      chk(low_err == 0, "R8 tx low in break", low_err, 0);
      chk(brk_active == 1'b0, "R7 break ended", brk_active, 0);
      if (mode == 2) chk(busy == 1'b0, "R4 R7 busy falls with break end", busy, 0);
      @(negedge clk);
      chk(brk_done == 1'b0, "R7 done one cycle", brk_done, 0);
      chk(tx_out == tx_in, "R8 tx passes after break", tx_out, tx_in);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R9 busy after reset", busy, 0);
      chk(brk_active == 1'b0, "R9 break idle after reset", brk_active, 0);
      chk(tx_out == tx_in, "R9 R8 tx passes", tx_out, tx_in);
      tx_in = 1'b0;
      @(negedge clk);
      chk(tx_out == 1'b0, "R8 tx follows low", tx_out, 0);
      tx_in = 1'b1;
      // R9: reset rate gives 13-cycle bits
      sync_bit();
      expect_bits(2, 0, 0);
      // R1: junk in bits 15:10 ignored -> P=1, D=2
      change_rate(20'h1_FC02, 0, 0, 1, 2);
      change_rate(20'h0_0004, 1, 2, 0, 4);
      change_rate(20'hF_0000, 0, 4, 15, 0);
      // R5: second write while busy ignored
      sync_bit();
      write_rate(20'h0_0001);
      chk(busy == 1'b1, "R4 busy", busy, 1);
      write_rate(20'h3_0007);
      wait_not_busy();
      expect_bits(2, 0, 1);
      // breaks
      run_break(3, 3, 0, 0, '0);
      run_break(0, 1, 0, 0, '0);
      run_break(2, 2, 1, 0, '0);
      // same-cycle: rate write after tick 2 applies on tick 3 = break end
      change_rate(20'h0_0000, 0, 1, 0, 0);
      run_break(3, 3, 2, 2, 20'h0_0001);
      expect_bits(2, 0, 1);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule